// File: doc/BRIEF.md
# NAND Controller Register File with Write-Unlock Key

This block is the host-visible control and status register file of a NAND flash controller. A 32-bit host bus with a byte address, write and read enables, byte strobes and write data reaches eight word registers. Two of them, the interface configuration and the timing word, are guarded by a 16-bit unlock key. The key permits exactly one subsequent write, and the guard then closes again by itself.

Hardware events from the rest of the controller arrive as one-cycle pulses. They latch into a sticky interrupt status register, which is gated by an interrupt mask to drive a level interrupt. Reading the status register clears it. A live status register passes the current controller conditions straight through. A chip-enable mode register and a command port complete the set. Writing the reset command to the command port pulses a soft-reset output and empties the sticky status.

Top module: `nand_ctrl_regs`

## Requirements
- R1: After reset, all registers read zero and every configuration output is zero. The lock reads locked, which is bit 0 of offset 0x14 equal to 0. `irq_o` and `soft_rst_o` are low.
- R2: A write of 0x A25E to offset 0x14 opens the guard. The write must carry bits 15:0 equal to 0xA25E with byte strobes 0 and 1 both set. While the guard is open, bit 0 of offset 0x14 reads 1.
- R3: A write to configuration (0x04) or timing (0x08) while the guard is closed changes nothing. A write of any other value to 0x14 closes the guard.
- R4: Any single write, to any offset other than 0x14, closes the guard again. This includes writes to unguarded registers.
- R5: The configuration register drives `cfg_o`. Its bits are: bit 0 selects a 16-bit bus, bit 1 selects 5-byte addressing, bit 2 selects large-block pages, and bit 3 selects write protect.
- R6: Writes update only the bytes whose strobe bit in `be_i` is set.
- R7: Mask (0x0C) and status (0x10) share one layout. Bit 0 is write-protect fault, bit 1 is ECC ready, bit 2 is decode error, bit 3 is decode failure, bit 4 is controller ready, and bit 5 is NAND ready. Each pulse on `evt_i` sets its status bit. `irq_o` is high in the cycle after an event whose mask bit is set, and stays high while any masked-in status bit is set.
- R8: Read data appears on `rdata_o` one cycle after `rd_en_i`. A read of 0x10 returns the status as it stood, then clears it.
- R9: An event pulse that arrives in the same cycle as a status read stays set after that read.
- R10: Offset 0x18 returns `live_i`. Bit 0 is NAND ready, bit 1 is controller ready, bit 2 is ECC ready, bit 3 is errors detected, bits 5:4 are the corrected-error count, and bit 6 is decoder failure.
- R11: Bit 0 of offset 0x1C drives `ce_normal_o` and reads back.
- R12: A write of 0xFF in byte 0 of offset 0x00 raises `soft_rst_o` for the single following cycle and clears the sticky status. Any other command byte leaves `soft_rst_o` low.
- R13: Reads of unmapped offsets return zero. Writes to the status (0x10) and live (0x18) offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| wr_en_i | input | 1 | Write enable |
| rd_en_i | input | 1 | Read enable |
| be_i | input | 4 | Byte strobes for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| evt_i | input | 6 | Event pulses in status bit layout |
| live_i | input | 7 | Live controller conditions |
| irq_o | output | 1 | Interrupt level |
| cfg_o | output | 4 | Interface configuration |
| timing_o | output | TIME_W | Timing word |
| ce_normal_o | output | 1 | Controller drives chip enable |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
Register writes, sticky status and mask changes show on their outputs one edge after the stimulus. The same holds for `irq_o` and `soft_rst_o`, so the bench compares them at the falling edge that follows the driving write or pulse. Read data is registered once. The driver therefore queues the expected word as it raises `rd_en_i`, and the monitor takes it from the queue just after the rising edge that captures the read. The case where a read and an event fall on the same edge is driven in a single cycle. Its effect is checked through a second read.

// File: rtl/nfc_regs_pkg.sv
package nfc_regs_pkg;
  localparam int unsigned IRQ_W  = 6;
  localparam int unsigned CFG_W  = 4;
  localparam int unsigned LIVE_W = 7;

  // word indices (byte offset / 4)
  localparam int unsigned OFF_CMD   = 0;
  localparam int unsigned OFF_CFG   = 1;
  localparam int unsigned OFF_TIM   = 2;
  localparam int unsigned OFF_IMASK = 3;
  localparam int unsigned OFF_ISTAT = 4;
  localparam int unsigned OFF_LOCK  = 5;
  localparam int unsigned OFF_LIVE  = 6;
  localparam int unsigned OFF_CE    = 7;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [7:0]  CMD_RST    = 8'hFF;

  typedef struct packed {
    logic cmd;
    logic cfg;
    logic tim;
    logic imask;
    logic istat;
    logic lock;
    logic live;
    logic ce;
  } reg_sel_t;
endpackage

// File: rtl/nfc_addr_dec.sv
module nfc_addr_dec
  import nfc_regs_pkg::*;
#(
  parameter int unsigned WIDX_W = 4
) (
  input  logic [WIDX_W-1:0] widx_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o = '0;
    case (widx_i)
      WIDX_W'(OFF_CMD):   sel_o.cmd   = 1'b1;
      WIDX_W'(OFF_CFG):   sel_o.cfg   = 1'b1;
      WIDX_W'(OFF_TIM):   sel_o.tim   = 1'b1;
      WIDX_W'(OFF_IMASK): sel_o.imask = 1'b1;
      WIDX_W'(OFF_ISTAT): sel_o.istat = 1'b1;
      WIDX_W'(OFF_LOCK):  sel_o.lock  = 1'b1;
      WIDX_W'(OFF_LIVE):  sel_o.live  = 1'b1;
      WIDX_W'(OFF_CE):    sel_o.ce    = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nfc_key_lock.sv
module nfc_key_lock
  import nfc_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        lock_sel_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] key_i,
  output logic        unlocked_o
);
  logic key_ok;
  logic open_q;

  assign key_ok = (be_i == 2'b11) && (key_i == UNLOCK_KEY);

  // every write decides the next state: only a correct key opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   open_q <= 1'b0;
    else if (wr_i) open_q <= lock_sel_i & key_ok;
  end

  assign unlocked_o = open_q;
endmodule

// File: rtl/nfc_byte_reg.sv
module nfc_byte_reg #(
  parameter int unsigned W  = 8,
  localparam int unsigned NB = (W + 7) / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NB-1:0] be_i,
  input  logic [W-1:0]  d_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] bit_en;
  logic [W-1:0] q_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_en[i] = en_i & be_i[i/8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~bit_en) | (d_i & bit_en);
  end

  assign q_o = q_q;
endmodule

// File: rtl/nfc_irq_ctrl.sv
module nfc_irq_ctrl #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  // a pulse landing on the clearing edge survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= evt_i | (clr_i ? '0 : stat_q);
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);
endmodule

// File: rtl/nand_ctrl_regs.sv
module nand_ctrl_regs
  import nfc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned TIME_W = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [IRQ_W-1:0]  evt_i,
  input  logic [LIVE_W-1:0] live_i,
  output logic              irq_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [TIME_W-1:0] timing_o,
  output logic              ce_normal_o,
  output logic              soft_rst_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned TIM_NB = (TIME_W + 7) / 8;

  reg_sel_t         sel;
  logic             unlocked;
  logic             cmd_rst;
  logic             stat_clr;
  logic [IRQ_W-1:0] mask_q;
  logic [IRQ_W-1:0] stat;
  logic [0:0]       ce_q;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             soft_rst_q;
  logic             unused_bits;

  assign unused_bits = ^{addr_i[1:0], wdata_i, be_i};

  nfc_addr_dec #(.WIDX_W(WIDX_W)) u_dec (
    .widx_i (addr_i[ADDR_W-1:2]),
    .sel_o  (sel)
  );

  nfc_key_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .lock_sel_i (sel.lock),
    .be_i       (be_i[1:0]),
    .key_i      (wdata_i[15:0]),
    .unlocked_o (unlocked)
  );

  nfc_byte_reg #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_i & sel.cfg & unlocked),
    .be_i   (be_i[0:0]),
    .d_i    (wdata_i[CFG_W-1:0]),
    .q_o    (cfg_o)
  );

  nfc_byte_reg #(.W(TIME_W)) u_tim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_i & sel.tim & unlocked),
    .be_i   (be_i[TIM_NB-1:0]),
    .d_i    (wdata_i[TIME_W-1:0]),
    .q_o    (timing_o)
  );

  nfc_byte_reg #(.W(IRQ_W)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_i & sel.imask),
    .be_i   (be_i[0:0]),
    .d_i    (wdata_i[IRQ_W-1:0]),
    .q_o    (mask_q)
  );

  nfc_byte_reg #(.W(1)) u_ce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wr_en_i & sel.ce),
    .be_i   (be_i[0:0]),
    .d_i    (wdata_i[0:0]),
    .q_o    (ce_q)
  );
  assign ce_normal_o = ce_q[0];

  assign cmd_rst  = wr_en_i & sel.cmd & be_i[0] & (wdata_i[7:0] == CMD_RST);
  assign stat_clr = (rd_en_i & sel.istat) | cmd_rst;

  nfc_irq_ctrl #(.N(IRQ_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (stat_clr),
    .mask_i (mask_q),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.cfg:   rd_mux = 32'(cfg_o);
      sel.tim:   rd_mux = 32'(timing_o);
      sel.imask: rd_mux = 32'(mask_q);
      sel.istat: rd_mux = 32'(stat);
      sel.lock:  rd_mux = 32'(unlocked);
      sel.live:  rd_mux = 32'(live_i);
      sel.ce:    rd_mux = 32'(ce_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      soft_rst_q <= 1'b0;
    end else begin
      rdata_q    <= rd_en_i ? rd_mux : '0;
      soft_rst_q <= cmd_rst;
    end
  end

  assign rdata_o    = rdata_q;
  assign soft_rst_o = soft_rst_q;
endmodule

// File: rtl/nand_ctrl_regs_chk.sv
module nand_ctrl_regs_chk
  import nfc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [3:0]        be_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [IRQ_W-1:0]  evt_i,
  input logic              irq_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              soft_rst_o,
  input logic              unlocked,
  input logic [IRQ_W-1:0]  mask_q
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  logic [WIDX_W-1:0] widx;
  assign widx = addr_i[ADDR_W-1:2];

  // R2
  key_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == WIDX_W'(OFF_LOCK) && be_i[1:0] == 2'b11 && wdata_i[15:0] == UNLOCK_KEY)
    |=> unlocked);

  // R3
  locked_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == WIDX_W'(OFF_CFG) && !unlocked) |=> $stable(cfg_o));

  // R4
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx != WIDX_W'(OFF_LOCK)) |=> !unlocked);

  // R7
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(evt_i & mask_q)) && !(wr_en_i && widx == WIDX_W'(OFF_IMASK))) |=> irq_o);

  // R12
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && widx == WIDX_W'(OFF_CMD) && be_i[0] && wdata_i[7:0] == CMD_RST) |=> soft_rst_o);

  // R13
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && widx > WIDX_W'(OFF_CE)) |=> (rdata_o == 32'h0));
endmodule

bind nand_ctrl_regs nand_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .be_i       (be_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .evt_i      (evt_i),
  .irq_o      (irq_o),
  .cfg_o      (cfg_o),
  .soft_rst_o (soft_rst_o),
  .unlocked   (unlocked),
  .mask_q     (mask_q)
);

// File: tb/nand_ctrl_regs_test.sv
`timescale 1ns/1ps
module nand_ctrl_regs_test;
  localparam int ADDR_W = 6;
  localparam int TIME_W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0] evt = '0;
  logic [6:0] live = '0;
  logic irq, ce_normal, soft_rst;
  logic [3:0] cfg;
  logic [TIME_W-1:0] timing;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  nand_ctrl_regs #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .live_i(live),
    .irq_o(irq), .cfg_o(cfg), .timing_o(timing), .ce_normal_o(ce_normal),
    .soft_rst_o(soft_rst)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
  endtask

  // driver: push expectation, issue read
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag,
                    input logic [5:0] ev = '0);
    @(negedge clk);
    addr = a; rd_en = 1'b1; evt = ev;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  // monitor: result due just after the edge that captured the read
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #1;
        if (exp_q.size() == 0) chk(rdata, 32'hX, "scoreboard underflow");
        else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(cfg), 0, "R1 cfg_o reset");
    chk(32'(timing), 0, "R1 timing_o reset");
    chk({29'd0, irq, ce_normal, soft_rst}, 0, "R1 irq/ce/soft reset");
    rd(6'h14, 0, "R1 lock reads locked");
    rd(6'h0C, 0, "R1 mask reset");

    // R3 locked write ignored
    wr(6'h04, 32'h6, 4'hF);
    chk(32'(cfg), 0, "R3 locked cfg write");
    // R2 key opens, R5 cfg layout
    wr(6'h14, 32'hA25E, 4'h3);
    rd(6'h14, 1, "R2 lock reads open");
    wr(6'h04, 32'h6, 4'hF);
    chk(32'(cfg), 32'h6, "R5 cfg large-block+long-addr");
    rd(6'h14, 0, "R2 relocked after one write");
    wr(6'h04, 32'hF, 4'hF);
    chk(32'(cfg), 32'h6, "R3 second write ignored");
    // R4 other register consumes unlock
    wr(6'h14, 32'hA25E, 4'h3);
    wr(6'h1C, 32'h0, 4'hF);
    wr(6'h04, 32'h9, 4'hF);
    chk(32'(cfg), 32'h6, "R4 unlock consumed by other write");
    // R3 wrong key
    wr(6'h14, 32'hA25F, 4'h3);
    wr(6'h08, 32'h1234, 4'hF);
    chk(32'(timing), 0, "R3 wrong key");
    // R6 byte strobes
    wr(6'h14, 32'hA25E, 4'h3);
    wr(6'h08, 32'hFFFF_FFFF, 4'b0011);
    chk(32'(timing), 32'h0000_FFFF, "R6 timing byte strobes");
    wr(6'h14, 32'hA25E, 4'h3);
    wr(6'h08, 32'h0755_0000, 4'b0100);
    chk(32'(timing), 32'h0055_FFFF, "R6 partial lane");

    // R7 masked event raises irq
    wr(6'h0C, 32'h10, 4'h1);
    pulse(6'h10);
    chk(32'(irq), 1, "R7 irq after controller-ready");
    rd(6'h10, 32'h10, "R8 status read value");
    @(negedge clk);
    chk(32'(irq), 0, "R8 irq low after clear");
    rd(6'h10, 0, "R8 status cleared");
    pulse(6'h04);
    chk(32'(irq), 0, "R7 unmasked event no irq");
    rd(6'h10, 32'h04, "R7 decode error latched");
    // R9 event on read edge
    rd(6'h10, 0, "R9 read during event", 6'h20);
    rd(6'h10, 32'h20, "R9 event kept");

    // R10 live status
    live = 7'h5A;
    rd(6'h18, 32'h5A, "R10 live status");
    live = 7'h25;
    rd(6'h18, 32'h25, "R10 live status 2");
    // R11 chip enable mode
    wr(6'h1C, 32'h1, 4'h1);
    chk(32'(ce_normal), 1, "R11 ce_normal_o");
    rd(6'h1C, 1, "R11 ce readback");

    // R13 unmapped and read-only
    rd(6'h3C, 0, "R13 unmapped read");
    wr(6'h10, 32'h3F, 4'hF);
    rd(6'h10, 0, "R13 status write ignored");
    wr(6'h18, 32'hFF, 4'hF);
    rd(6'h18, 32'h25, "R13 live write ignored");

    // R12 soft reset
    pulse(6'h01);
    wr(6'h00, 32'h00, 4'h1);
    chk(32'(soft_rst), 0, "R12 non-reset command");
    wr(6'h00, 32'hFF, 4'h1);
    chk(32'(soft_rst), 1, "R12 soft reset pulse");
    @(negedge clk);
    chk(32'(soft_rst), 0, "R12 pulse single cycle");
    rd(6'h10, 0, "R12 status cleared by reset cmd");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 0, "scoreboard drained");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule